// File: doc/BRIEF.md
# Self-correcting timing-phase generator

This block drives the timing phases of a control unit that works in parallel mode. It produces `NUM_PHASES` one-hot phase lines, T0 first. One clock period later the next line takes over, and after the last phase the rotation wraps back to T0. An enable input advances the rotation or holds it. A parameter chooses how the state is stored. The ring form is a circular shift register that carries a single 1. The counter form is a binary counter that feeds a one-hot decoder. For identical inputs, both forms give the same waveform on `phase_o`, cycle for cycle.

Both forms recover from a bad state by themselves. In the ring, a pattern with no 1 or with several 1s is replaced by the T0 pattern. In a counter whose code space is larger than the phase count, for example three phases in a 2-bit counter, any unused code returns to code 0. While the state is bad, every phase line is low. Recovery takes one clock, whatever the enable input is doing. A test-load port writes any raw state word, legal or not, so fault recovery can be exercised from the ports.

Top module: `phase_gen`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it rises, `phase_o` equals T0 (bit 0 set, all other bits clear).
- R2: With `en_i` high and no load, the single active line moves from bit k to bit k+1 on each rising clock edge. It wraps from bit `NUM_PHASES-1` to bit 0, so every phase lasts exactly one clock period.
- R3: With `en_i` low and no load, a legal phase holds unchanged across clock edges.
- R4: `phase_o` never has more than one bit set. It has exactly one bit set whenever the stored state is legal.
- R5: Ring form: state bit i stands for phase i, and a word is legal only when exactly one bit is set. While an illegal word (all zero, or two or more ones) is held, `phase_o` is all zero. On the next edge the state becomes T0, whatever `en_i` is.
- R6: Counter form: code k stands for phase k. Codes k ≥ `NUM_PHASES` are illegal (code 3 when there are three phases). While an illegal code is held, `phase_o` is all zero. On the next edge the state becomes code 0, whatever `en_i` is.
- R7: `test_load_i` high writes `test_state_i` into the state on the next edge. The load takes precedence over both advancing and correction. The load word is `NUM_PHASES` bits wide in ring form and `ceil(log2 NUM_PHASES)` bits wide in counter form.
- R8: With the same `NUM_PHASES`, reset and enable sequence, the ring and counter forms produce identical `phase_o` on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; forces T0 |
| en_i | input | 1 | Advance to the next phase when high, hold when low |
| test_load_i | input | 1 | Write `test_state_i` into the state on the next edge |
| test_state_i | input | STATE_W | Raw state word: one bit per phase (ring) or a binary code (counter) |
| phase_o | output | NUM_PHASES | One-hot timing phases, bit 0 is T0 |

## Verification
The bench builds four instances: four and three phases, each in ring form and in counter form. The four-phase pair is compared line by line while both see the same reset and enable sequence, which checks the claim that the two forms are equivalent. The three-phase counter has a truly unused code, so it is the only instance that can reach counter repair. The three-phase ring cuts the four-bit load patterns down to three bits and so meets a different set of illegal words. A behavioural model of the phase index checks every instance on every cycle, through loads of zero, multiple-one and legal words with the enable input both high and low.

// File: rtl/phase_gen_pkg.sv
package phase_gen_pkg;
  typedef enum logic {
    IMPL_RING  = 1'b0,
    IMPL_COUNT = 1'b1
  } phase_impl_e;
endpackage

// File: rtl/phase_ring.sv
module phase_ring #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [N-1:0] load_val_i,
  output logic [N-1:0] phase_o
);
  localparam logic [N-1:0] T0 = N'(1);

  logic [N-1:0] state_q, state_d;
  logic         legal;

  assign legal = $onehot(state_q);

  always_comb begin
    state_d = state_q;
    if (load_i)      state_d = load_val_i;
    else if (!legal) state_d = T0;  // repair: zero or multi-hot
    else if (en_i)   state_d = {state_q[N-2:0], state_q[N-1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= T0;
    else         state_q <= state_d;
  end

  assign phase_o = legal ? state_q : '0;

  // R5: illegal word is replaced by T0 after one edge
  a_r5_ring_repair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && $countones(state_q) != 1) |=> state_q == T0);

  // R7: load takes the raw word
  a_r7_ring_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> state_q == $past(load_val_i));
endmodule

// File: rtl/phase_cnt.sv
module phase_cnt #(
  parameter int unsigned N  = 4,
  parameter int unsigned CW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic [CW-1:0] code_o
);
  localparam logic [CW:0]   N_EXT = (CW+1)'(N);
  localparam logic [CW-1:0] LAST  = CW'(N - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          legal;

  assign legal = {1'b0, cnt_q} < N_EXT;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (!legal) cnt_d = '0;  // unused code back to phase 0
    else if (en_i)   cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign code_o = cnt_q;

  // R6: unused code returns to 0 after one edge
  a_r6_cnt_repair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && int'(cnt_q) >= int'(N)) |=> cnt_q == '0);

  // R7: load takes the raw code
  a_r7_cnt_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/phase_dec.sv
module phase_dec #(
  parameter int unsigned N  = 4,
  parameter int unsigned CW = 2
) (
  input  logic [CW-1:0] code_i,
  output logic [N-1:0]  phase_o
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign phase_o[i] = (code_i == CW'(i));
  end
endmodule

// File: rtl/phase_gen.sv
module phase_gen
  import phase_gen_pkg::*;
#(
  parameter int unsigned NUM_PHASES = 4,
  parameter phase_impl_e IMPL       = IMPL_RING,
  localparam int unsigned CNT_W     = $clog2(NUM_PHASES),
  localparam int unsigned STATE_W   = (IMPL == IMPL_RING) ? NUM_PHASES : CNT_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  en_i,
  input  logic                  test_load_i,
  input  logic [STATE_W-1:0]    test_state_i,
  output logic [NUM_PHASES-1:0] phase_o
);
  localparam int unsigned N = NUM_PHASES;

  if (IMPL == IMPL_RING) begin : g_ring
    phase_ring #(.N(N)) u_ring (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i),
      .load_i     (test_load_i),
      .load_val_i (test_state_i),
      .phase_o    (phase_o)
    );
  end else begin : g_count
    logic [CNT_W-1:0] code;
    phase_cnt #(.N(N), .CW(CNT_W)) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (en_i),
      .load_i     (test_load_i),
      .load_val_i (test_state_i),
      .code_o     (code)
    );
    phase_dec #(.N(N), .CW(CNT_W)) u_dec (
      .code_i  (code),
      .phase_o (phase_o)
    );
  end

  // R4: never more than one line active
  a_r4_onehot0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(phase_o));

  // R2: active line rotates by one each enabled edge
  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !test_load_i && phase_o != '0)
      |=> phase_o == {$past(phase_o[N-2:0]), $past(phase_o[N-1])});

  // R3: hold while disabled
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !test_load_i && phase_o != '0) |=> $stable(phase_o));

  // R5 R6: an empty phase is followed by T0 unless loaded
  a_r5_r6_recover: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!test_load_i && phase_o == '0) |=> phase_o == N'(1));
endmodule

// File: tb/phase_gen_tb.sv
module phase_gen_tb_lane
  import phase_gen_pkg::*;
#(
  parameter int unsigned N    = 4,
  parameter phase_impl_e IMPL = IMPL_RING
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         ld,
  input  logic [3:0]   ld_val,
  input  int           req,
  output logic [N-1:0] phase,
  output int           n_chk,
  output int           n_fail
);
  localparam int CW = $clog2(N);
  localparam int SW = (IMPL == IMPL_RING) ? N : CW;

  phase_gen #(.NUM_PHASES(N), .IMPL(IMPL)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .test_load_i  (ld),
    .test_state_i (ld_val[SW-1:0]),
    .phase_o      (phase)
  );

  int idx = 0;   // model phase index, -1 = illegal
  int chk = 0;
  int bad = 0;
  assign n_chk  = chk;
  assign n_fail = bad;

  function automatic int decode(logic [3:0] v);
    int pos = -1;
    if (IMPL == IMPL_RING) begin
      if ($countones(v[SW-1:0]) == 1)
        for (int i = 0; i < SW; i++) if (v[i]) pos = i;
    end else begin
      if (int'(v[CW-1:0]) < int'(N)) pos = int'(v[CW-1:0]);
    end
    return pos;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx = 0;
    else if (ld)      idx = decode(ld_val);
    else if (idx < 0) idx = 0;
    else if (en)      idx = (idx + 1) % int'(N);
  end

  always @(negedge clk) begin
    logic [N-1:0] e;
    e = '0;
    if (idx >= 0) e[idx] = 1'b1;
    chk++;
    if (phase !== e) begin
      bad++;
      $display("FAIL R%0d lane N=%0d %s: phase=%b expected=%b",
               req, N, (IMPL == IMPL_RING) ? "ring" : "count", phase, e);
    end
  end
endmodule

module phase_gen_tb;
  import phase_gen_pkg::*;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       ld = 1'b0;
  logic [3:0] ld_val = '0;
  int         req = 1;
  logic       cross_en = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  int         x_chk = 0, x_fail = 0;
  bit         done = 1'b0;

  logic [3:0] ph_r4, ph_c4;
  logic [2:0] ph_r3, ph_c3;
  int c0, c1, c2, c3, f0, f1, f2, f3;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_gen_tb_lane #(.N(4), .IMPL(IMPL_RING)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .ld(ld), .ld_val(ld_val), .req(req),
    .phase(ph_r4), .n_chk(c0), .n_fail(f0));
  phase_gen_tb_lane #(.N(4), .IMPL(IMPL_COUNT)) u_c4 (
    .clk(clk), .rst_n(rst_n), .en(en), .ld(ld), .ld_val(ld_val), .req(req),
    .phase(ph_c4), .n_chk(c1), .n_fail(f1));
  phase_gen_tb_lane #(.N(3), .IMPL(IMPL_RING)) u_r3 (
    .clk(clk), .rst_n(rst_n), .en(en), .ld(ld), .ld_val(ld_val), .req(req),
    .phase(ph_r3), .n_chk(c2), .n_fail(f2));
  phase_gen_tb_lane #(.N(3), .IMPL(IMPL_COUNT)) u_c3 (
    .clk(clk), .rst_n(rst_n), .en(en), .ld(ld), .ld_val(ld_val), .req(req),
    .phase(ph_c3), .n_chk(c3), .n_fail(f3));

  // R8: ring and counter forms match while driven alike
  always @(negedge clk) begin
    if (cross_en) begin
      x_chk++;
      if (ph_r4 !== ph_c4) begin
        x_fail++;
        $display("FAIL R8 ring=%b count=%b (expected equal)", ph_r4, ph_c4);
      end
    end
  end

  task automatic summary(input int extra_fail);
    int tot, bad;
    tot = c0 + c1 + c2 + c3 + x_chk + extra_fail;
    bad = f0 + f1 + f2 + f3 + x_fail + extra_fail;
    $display("  %0d/%0d checks passed", tot - bad, tot);
  endtask

  task automatic step(input logic e, input logic l, input logic [3:0] v);
    @(negedge clk);
    en = e; ld = l; ld_val = v;
  endtask

  task automatic run_lfsr(input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] | lfsr[3], 1'b0, '0);
    end
  endtask

  initial begin
    logic [3:0] pats [10] = '{4'b0000, 4'b1111, 4'b0101, 4'b0011, 4'b0110,
                              4'b0100, 4'b1000, 4'b0111, 4'b0010, 4'b1011};
    // R1: reset state
    req = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cross_en = 1'b1;
    step(1'b0, 1'b0, '0);
    // R2: free-running rotation
    req = 2;
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, '0);
    // R3 R8: irregular enable
    req = 3;
    run_lfsr(40);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, '0);
    // R5 R6 R7: loads of legal and illegal words, enable high and low
    cross_en = 1'b0;
    req = 7;
    foreach (pats[k]) begin
      step(k[0], 1'b1, pats[k]);
      step(k[1], 1'b0, '0);
      step(1'b0, 1'b0, '0);
      step(1'b1, 1'b0, '0);
    end
    // R7: back-to-back loads, illegal then legal
    step(1'b1, 1'b1, 4'b0000);
    step(1'b1, 1'b1, 4'b0001);
    step(1'b0, 1'b1, 4'b1111);
    step(1'b1, 1'b0, '0);
    step(1'b1, 1'b0, '0);
    // R1: asynchronous reset mid-run
    req = 1;
    @(negedge clk);
    rst_n = 1'b0; en = 1'b1; ld = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    en = 1'b0;
    cross_en = 1'b1;
    // R8: equivalence after common reset
    req = 8;
    run_lfsr(30);
    @(negedge clk);
    done = 1'b1;
    summary(0);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      $display("FAIL watchdog: run hung (actual=timeout expected=finish)");
      summary(1);
      $finish;
    end
  end
endmodule